// File: doc/BRIEF.md
# Spare-Core Rotating Calibration Sequencer

This controller decides when each core of an interleaved converter is calibrated. The converter has `N_ACT` cores that produce data and one extra core. At any moment exactly `N_ACT` cores are marked on-line. The controller drives a power enable, a calibrate request and an on-line flag for every core. Each core answers with a one-cycle completion pulse when its calibration finishes.

Foreground operation stops the output and calibrates every core in turn. This always happens once right after reset. It happens again whenever a trigger arrives while background operation is off. The trigger comes from either an external pin or a software bit, and a configuration input selects which one.

Background operation keeps the data flowing. The off-line spare is calibrated first. It is then swapped in for the next core in round-robin order, and that core becomes the new spare. Rotation is either automatic or advanced one step per trigger.

A low-power option powers the spare down between rotations. In automatic timing it sleeps for a programmed time. In trigger-driven timing it sleeps until a trigger arrives. It then waits a programmed wake time before its calibration starts.

Top module: `spare_cal_seq`

## Requirements
- R1: While reset is held and in the first cycle after it: `conv_valid`=0, `done`=0, `busy`=1, `core_cal`=only bit 0, `core_online`=bits 0..N_ACT-1 set with the top bit clear, all `core_pwr` bits set, `rot_count`=0.
- R2: A foreground pass raises `core_cal` for cores 0 up to N_ACT in index order, once each. The next request rises in the cycle after the completion pulse of the current core is sampled. `conv_valid` stays 0 for the whole pass. After the last core, `conv_valid`=1, `busy`=0, and `done` becomes 1 and never falls again.
- R3: `trig_sel`=1 selects `trig_pin` and `trig_sel`=0 selects `sw_trig`. With `bg_en`=0 a rising edge of the selected source starts one foreground pass. Edges of the unselected source start nothing.
- R4: A trigger edge that arrives while a calibration is running is held and serviced once after it. Several such edges cause only one extra pass.
- R5: In background operation the spare is calibrated while off-line. On its completion pulse, the spare's on-line bit sets and the bit of core (spare+1) mod (N_ACT+1) clears, both in the same cycle, and `rot_count` increments by one. Exactly N_ACT on-line bits are set at all times.
- R6: With `bg_en`=1, `lp_en`=0 and `lp_manual`=0, rotations follow each other while the selected trigger level is 1. `conv_valid` stays 1 throughout.
- R7: With `bg_en`=1 and `lp_manual`=1, each trigger edge starts exactly one rotation. Without an edge no rotation occurs.
- R8: With `lp_en`=1 and `lp_manual`=0, the spare's `core_pwr` bit is 0 for `sleep_dly`+1 cycles before it wakes.
- R9: In low-power operation, the spare's `core_cal` bit rises `wake_dly`+1 cycles after its `core_pwr` bit rises.
- R10: With `lp_en`=1 and `lp_manual`=1, the spare stays powered down, with no rotation, until a trigger edge arrives.
- R11: At most one `core_cal` bit is set. A calibrate request never goes to a powered-down core. A powered-down core is never on-line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the power-up foreground pass |
| trig_pin | input | 1 | External trigger source |
| sw_trig | input | 1 | Software trigger source |
| trig_sel | input | 1 | 1 = pin source, 0 = software source |
| bg_en | input | 1 | Enables background rotation |
| lp_en | input | 1 | Powers the spare down between rotations |
| lp_manual | input | 1 | 1 = rotation advanced by trigger edges, 0 = automatic |
| sleep_dly | input | DLY_W | Sleep time for automatic low-power timing |
| wake_dly | input | DLY_W | Settling time after wake-up |
| core_done | input | N_ACT+1 | Per-core calibration completion pulse |
| core_pwr | output | N_ACT+1 | Per-core power enable |
| core_cal | output | N_ACT+1 | Per-core calibration request |
| core_online | output | N_ACT+1 | Per-core on-line flag |
| conv_valid | output | 1 | Converter output valid (0 during a foreground pass) |
| busy | output | 1 | A calibration or wake-up is in progress |
| done | output | 1 | Power-up foreground pass has completed |
| rot_count | output | CNT_W | Count of completed background rotations |

## Verification
A wrong spare pointer shows up at the very next rotation. Either the calibrate request goes to a core that is on-line, or the on-line swap clears the wrong bit. Both are visible the cycle they happen, and the cycle-accurate order of calibrated cores exposes them. A wrong timer limit or entry point shifts the power-enable or calibrate edge by a cycle, and the bench measures both windows exactly. A lost or doubled pending trigger shows as a missing or extra pass, which the scoreboard reports as an unexpected or leftover calibration.

// File: rtl/scs_pkg.sv
package scs_pkg;
    typedef enum logic [2:0] {
        ST_FG    = 3'd0,
        ST_IDLE  = 3'd1,
        ST_SLEEP = 3'd2,
        ST_WAKE  = 3'd3,
        ST_BG    = 3'd4
    } scs_state_e;
endpackage

// File: rtl/scs_trig.sv
module scs_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sw,
    input  logic sel,
    input  logic consume,
    output logic level,
    output logic pend
);
    logic src_d, src_q;
    logic pend_d, pend_q;
    logic rise;

    always_comb begin
        level  = sel ? pin : sw;
        src_d  = level;
        rise   = level & ~src_q;
        pend_d = rise | (pend_q & ~consume);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            src_q  <= src_d;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/scs_timer.sv
module scs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (cnt_q != '1)
            cnt_d = cnt_q + W'(1);
        hit = (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spare_cal_seq.sv
module spare_cal_seq
    import scs_pkg::*;
#(
    parameter int N_ACT = 4,
    parameter int DLY_W = 8,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_pin,
    input  logic               sw_trig,
    input  logic               trig_sel,
    input  logic               bg_en,
    input  logic               lp_en,
    input  logic               lp_manual,
    input  logic [DLY_W-1:0]   sleep_dly,
    input  logic [DLY_W-1:0]   wake_dly,
    input  logic [N_ACT:0]     core_done,
    output logic [N_ACT:0]     core_pwr,
    output logic [N_ACT:0]     core_cal,
    output logic [N_ACT:0]     core_online,
    output logic               conv_valid,
    output logic               busy,
    output logic               done,
    output logic [CNT_W-1:0]   rot_count
);
    localparam int NC = N_ACT + 1;
    localparam int IW = $clog2(NC);
    localparam logic [NC-1:0] ONE = NC'(1);
    localparam logic [IW-1:0] LAST = IW'(NC - 1);

    typedef struct packed {
        scs_state_e       st;
        logic [IW-1:0]    idx;
        logic [IW-1:0]    sp;
        logic [NC-1:0]    pwr;
        logic [NC-1:0]    cal;
        logic [NC-1:0]    onl;
        logic             conv;
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] rot;
    } regs_t;

    localparam regs_t RST = '{
        st:   ST_FG,
        idx:  '0,
        sp:   LAST,
        pwr:  '1,
        cal:  ONE,
        onl:  {1'b0, {N_ACT{1'b1}}},
        conv: 1'b0,
        busy: 1'b1,
        done: 1'b0,
        rot:  '0
    };

    regs_t d, q;
    logic  trig_lvl, trig_pend, consume;
    logic  tmr_clr, tmr_hit;
    logic [DLY_W-1:0] tmr_lim;
    logic [IW-1:0]    victim;

    scs_trig i_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (trig_pin),
        .sw      (sw_trig),
        .sel     (trig_sel),
        .consume (consume),
        .level   (trig_lvl),
        .pend    (trig_pend)
    );

    assign tmr_lim = (q.st == ST_SLEEP) ? sleep_dly : wake_dly;

    scs_timer #(.W(DLY_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (tmr_lim),
        .hit   (tmr_hit)
    );

    always_comb begin
        d       = q;
        consume = 1'b0;
        victim  = (q.sp == LAST) ? '0 : q.sp + IW'(1);
        case (q.st)
            ST_FG: begin
                if (core_done[q.idx]) begin
                    if (q.idx == LAST) begin
                        d.st   = ST_IDLE;
                        d.cal  = '0;
                        d.conv = 1'b1;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + IW'(1);
                        d.cal = ONE << (q.idx + IW'(1));
                    end
                end
            end
            ST_IDLE: begin
                if (!bg_en) begin
                    if (trig_pend) begin
                        d.st    = ST_FG;
                        d.idx   = '0;
                        d.cal   = ONE;
                        d.conv  = 1'b0;
                        d.busy  = 1'b1;
                        consume = 1'b1;
                    end
                end else if (lp_en) begin
                    d.st        = ST_SLEEP;
                    d.pwr[q.sp] = 1'b0;
                end else if (lp_manual ? trig_pend : trig_lvl) begin
                    d.st    = ST_BG;
                    d.cal   = ONE << q.sp;
                    d.busy  = 1'b1;
                    consume = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (!bg_en || !lp_en) begin
                    d.st        = ST_IDLE;
                    d.pwr[q.sp] = 1'b1;
                end else if (lp_manual ? trig_pend : tmr_hit) begin
                    d.st        = ST_WAKE;
                    d.pwr[q.sp] = 1'b1;
                    d.busy      = 1'b1;
                    consume     = 1'b1;
                end
            end
            ST_WAKE: begin
                if (tmr_hit) begin
                    d.st  = ST_BG;
                    d.cal = ONE << q.sp;
                end
            end
            ST_BG: begin
                if (core_done[q.sp]) begin
                    d.st         = ST_IDLE;
                    d.cal        = '0;
                    d.busy       = 1'b0;
                    d.onl[victim] = 1'b0;
                    d.onl[q.sp]  = 1'b1;
                    d.sp         = victim;
                    d.rot        = q.rot + CNT_W'(1);
                end
            end
            default: d = RST;
        endcase
        tmr_clr = (d.st != q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign core_pwr    = q.pwr;
    assign core_cal    = q.cal;
    assign core_online = q.onl;
    assign conv_valid  = q.conv;
    assign busy        = q.busy;
    assign done        = q.done;
    assign rot_count   = q.rot;
endmodule

// File: rtl/scs_chk.sv
module scs_chk #(
    parameter int N_ACT = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_ACT:0]   core_pwr,
    input logic [N_ACT:0]   core_cal,
    input logic [N_ACT:0]   core_online,
    input logic             conv_valid,
    input logic             done,
    input logic [CNT_W-1:0] rot_count
);
    // R5
    online_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(core_online) == N_ACT);

    // R5
    swap_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_online) |-> (rot_count == $past(rot_count) + CNT_W'(1)));

    // R11
    one_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_cal));

    // R11
    cal_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_cal & ~core_pwr) == '0);

    // R11
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_online & ~core_pwr) == '0);

    // R2
    fg_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(core_cal & core_online)) |-> !conv_valid);

    // R2
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

bind spare_cal_seq scs_chk #(.N_ACT(N_ACT), .CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_pwr    (core_pwr),
    .core_cal    (core_cal),
    .core_online (core_online),
    .conv_valid  (conv_valid),
    .done        (done),
    .rot_count   (rot_count)
);

// File: tb/test_spare_cal_seq.sv
module test_spare_cal_seq;
    localparam int N_ACT = 4;
    localparam int NC    = N_ACT + 1;
    localparam int DLY_W = 8;
    localparam int CNT_W = 16;
    localparam int LAT   = 3;
    localparam int SLP   = 5;
    localparam int WAK   = 3;
    localparam logic [NC-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_pin = 1'b0, sw_trig = 1'b0, trig_sel = 1'b0;
    logic bg_en = 1'b0, lp_en = 1'b0, lp_manual = 1'b0;
    logic [DLY_W-1:0] sleep_dly = DLY_W'(SLP);
    logic [DLY_W-1:0] wake_dly  = DLY_W'(WAK);
    logic [NC-1:0] core_done, core_pwr, core_cal, core_online;
    logic conv_valid, busy, done;
    logic [CNT_W-1:0] rot_count;

    int n_chk = 0, n_bad = 0;
    int exp_cal[$];
    logic [NC-1:0] exp_onl[$];
    string cur_req = "R2";
    int sp_b = NC - 1;
    bit chk_sleep = 0;
    bit bg_phase = 0;
    bit conv_drop = 0;
    int n_slp = 0, n_wak = 0;

    always #4 clk = ~clk;

    spare_cal_seq #(.N_ACT(N_ACT), .DLY_W(DLY_W), .CNT_W(CNT_W)) i_spare_cal_seq (
        .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .sw_trig(sw_trig),
        .trig_sel(trig_sel), .bg_en(bg_en), .lp_en(lp_en), .lp_manual(lp_manual),
        .sleep_dly(sleep_dly), .wake_dly(wake_dly), .core_done(core_done),
        .core_pwr(core_pwr), .core_cal(core_cal), .core_online(core_online),
        .conv_valid(conv_valid), .busy(busy), .done(done), .rot_count(rot_count)
    );

    // core model: completion pulse LAT+1 cycles after request rises
    int lat_cnt [NC];
    always @(posedge clk) begin
        for (int i = 0; i < NC; i++)
            lat_cnt[i] <= core_cal[i] ? lat_cnt[i] + 1 : 0;
    end
    for (genvar g = 0; g < NC; g++) begin : g_core
        assign core_done[g] = core_cal[g] && (lat_cnt[g] == LAT);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic push_rot;
        int v;
        v = (sp_b + 1) % NC;
        exp_cal.push_back(sp_b);
        exp_onl.push_back(ALL & ~(NC'(1) << v));
        sp_b = v;
    endtask

    task automatic push_fg;
        for (int i = 0; i < NC; i++) exp_cal.push_back(i);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rot(input int target);
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (int'(rot_count) != target && n < 3000);
    endtask

    task automatic pulse_sw;
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic pulse_pin;
        @(negedge clk); trig_pin = 1'b1;
        @(negedge clk); trig_pin = 1'b0;
    endtask

    // monitor / scoreboard
    logic [NC-1:0] cal_prev, onl_prev, pwr_prev;
    int slp_cnt [NC];
    int wk_cnt [NC];
    bit wk_on [NC];
    always @(negedge clk) begin
        if (!rst_n) begin
            cal_prev = '0;
            onl_prev = core_online;
            pwr_prev = core_pwr;
            for (int i = 0; i < NC; i++) begin
                slp_cnt[i] = 0; wk_cnt[i] = 0; wk_on[i] = 0;
            end
        end else begin
            for (int i = 0; i < NC; i++) begin
                if (core_cal[i] && !cal_prev[i]) begin
                    if (exp_cal.size() == 0)
                        chk(0, {cur_req, " unexpected calibration"}, i, -1);
                    else
                        chk(exp_cal.pop_front() == i, {cur_req, " calibration order"}, i, -2);
                end
                if (core_pwr[i] && !pwr_prev[i]) begin
                    if (chk_sleep) begin
                        chk(slp_cnt[i] == SLP + 1, "R8 sleep length", slp_cnt[i], SLP + 1);
                        n_slp++;
                    end
                    slp_cnt[i] = 0;
                    wk_on[i] = 1;
                    wk_cnt[i] = 1;
                end else if (!core_pwr[i]) begin
                    slp_cnt[i]++;
                end else if (wk_on[i] && !core_cal[i]) begin
                    wk_cnt[i]++;
                end
                if (wk_on[i] && core_cal[i]) begin
                    chk(wk_cnt[i] == WAK + 1, "R9 wake length", wk_cnt[i], WAK + 1);
                    n_wak++;
                    wk_on[i] = 0;
                end
            end
            if (core_online != onl_prev) begin
                if (exp_onl.size() == 0)
                    chk(0, "R5 unexpected online change", int'(core_online), -1);
                else
                    chk(exp_onl.pop_front() == core_online, "R5 online swap", int'(core_online), -2);
            end
            if (bg_phase && !conv_valid) conv_drop = 1;
            cal_prev = core_cal;
            onl_prev = core_online;
            pwr_prev = core_pwr;
        end
    end

    initial begin
        #(8 * 150000);
        chk(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        // R1 reset state
        wait_cyc(3);
        chk(conv_valid == 1'b0, "R1 conv_valid", conv_valid, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(busy == 1'b1, "R1 busy", busy, 1);
        chk(core_cal == NC'(1), "R1 core_cal", int'(core_cal), 1);
        chk(core_online == (ALL >> 1), "R1 core_online", int'(core_online), int'(ALL >> 1));
        chk(core_pwr == ALL, "R1 core_pwr", int'(core_pwr), int'(ALL));
        chk(rot_count == '0, "R1 rot_count", int'(rot_count), 0);
        push_fg();
        cur_req = "R2";
        rst_n = 1'b1;
        @(negedge clk);
        chk(core_cal == NC'(1) && !conv_valid, "R1 first cycle", int'(core_cal), 1);
        wait_cyc(2);
        chk(conv_valid == 1'b0, "R2 output halted during pass", conv_valid, 0);
        wait_cyc(60);
        chk(done == 1'b1, "R2 done", done, 1);
        chk(conv_valid == 1'b1, "R2 conv_valid after pass", conv_valid, 1);
        chk(busy == 1'b0, "R2 busy after pass", busy, 0);
        chk(exp_cal.size() == 0, "R2 all cores calibrated", exp_cal.size(), 0);

        // R3: unselected source ignored, selected pin starts a pass
        cur_req = "R3";
        trig_sel = 1'b1;
        pulse_sw();
        wait_cyc(30);
        chk(busy == 1'b0 && core_cal == '0, "R3 unselected source ignored", int'(busy), 0);
        push_fg();
        pulse_pin();
        wait_cyc(60);
        chk(exp_cal.size() == 0, "R3 pin pass completed", exp_cal.size(), 0);
        chk(done == 1'b1 && conv_valid == 1'b1, "R3 back to normal output", int'(conv_valid), 1);

        // R4: soft trigger, edges during a pass cause exactly one more pass
        cur_req = "R4";
        trig_sel = 1'b0;
        push_fg();
        push_fg();
        pulse_sw();
        wait_cyc(4);
        chk(busy == 1'b1, "R4 pass running", busy, 1);
        pulse_sw();
        pulse_sw();
        wait_cyc(150);
        chk(exp_cal.size() == 0, "R4 pending pass serviced", exp_cal.size(), 0);
        chk(busy == 1'b0, "R4 no further pass", busy, 0);

        // R5/R6: automatic background rotation
        cur_req = "R6";
        for (int k = 0; k < 6; k++) push_rot();
        bg_phase = 1;
        conv_drop = 0;
        @(negedge clk);
        bg_en = 1'b1;
        sw_trig = 1'b1;
        wait_rot(6);
        sw_trig = 1'b0;
        wait_cyc(20);
        chk(int'(rot_count) == 6, "R5 rotation count", int'(rot_count), 6);
        chk(exp_cal.size() == 0 && exp_onl.size() == 0, "R5 rotation order", exp_cal.size(), 0);
        chk(conv_drop == 0, "R6 output uninterrupted", int'(conv_drop), 0);

        // R7: trigger-driven rotation
        cur_req = "R7";
        lp_manual = 1'b1;
        wait_cyc(25);
        chk(int'(rot_count) == 6, "R7 no rotation without trigger", int'(rot_count), 6);
        push_rot();
        pulse_sw();
        wait_cyc(40);
        chk(int'(rot_count) == 7, "R7 one rotation per trigger", int'(rot_count), 7);
        chk(exp_cal.size() == 0 && exp_onl.size() == 0, "R7 rotation order", exp_cal.size(), 0);

        // R8/R9: low-power automatic timing
        cur_req = "R8";
        for (int k = 0; k < 3; k++) push_rot();
        chk_sleep = 1;
        @(negedge clk);
        lp_manual = 1'b0;
        lp_en = 1'b1;
        wait_rot(10);
        lp_en = 1'b0;
        wait_cyc(10);
        chk_sleep = 0;
        chk(n_slp == 3, "R8 sleep windows seen", n_slp, 3);
        chk(n_wak == 3, "R9 wake windows seen", n_wak, 3);
        chk(exp_cal.size() == 0 && exp_onl.size() == 0, "R8 rotation order", exp_cal.size(), 0);
        chk(conv_drop == 0, "R6 output uninterrupted in low power", int'(conv_drop), 0);

        // R10: low-power trigger-driven timing
        cur_req = "R10";
        @(negedge clk);
        lp_manual = 1'b1;
        lp_en = 1'b1;
        wait_cyc(40);
        chk(core_pwr[sp_b] == 1'b0, "R10 spare stays asleep", int'(core_pwr[sp_b]), 0);
        chk(int'(rot_count) == 10, "R10 no rotation while asleep", int'(rot_count), 10);
        push_rot();
        pulse_sw();
        wait_rot(11);
        lp_en = 1'b0;
        wait_cyc(10);
        chk(int'(rot_count) == 11, "R10 rotation after trigger", int'(rot_count), 11);
        chk(n_wak == 4, "R9 wake after trigger", n_wak, 4);
        chk(exp_cal.size() == 0 && exp_onl.size() == 0, "R10 rotation order", exp_cal.size(), 0);
        chk(core_pwr == ALL, "R10 all powered after exit", int'(core_pwr), int'(ALL));
        report();
    end
endmodule